// File: doc/BRIEF.md
# Two-Input Pair-Sequence Output Controller

This block is a Moore machine. It watches a 2-bit input symbol formed from two single-bit inputs, `in_a` as the high bit and `in_b` as the low bit, and samples it on every rising clock edge. It drives one registered output, `z_out`. The output is set, cleared or inverted according to the ordered pair formed by the previous symbol and the current one. Every other pair leaves the output as it is.

Internally the machine keeps two things. The first is the class of the previous symbol: "flat" for 00 or 11, "rise" for 01, "fall" for 10. The second is the present output bit. Together they give six states. A parameter selects how these states are stored: as a binary class register next to an output flop, or as a six-bit one-hot register. The behaviour at the ports is the same for both.

Top module: `pairseq_ctrl`

## Requirements
- R1: A synchronous reset puts the machine in the flat class with `z_out` = 0, so the first symbol after reset is paired with a flat predecessor.
- R2: A rise symbol (`in_a`=0, `in_b`=1) followed by the symbol 11 makes `z_out` 0.
- R3: A fall symbol (`in_a`=1, `in_b`=0) followed by the symbol 11 makes `z_out` 1.
- R4: A fall symbol followed by a rise symbol inverts `z_out`.
- R5: Every other ordered pair of symbols leaves `z_out` unchanged. This covers any pair whose first symbol is 00 or 11, and any pair whose second symbol is 00.
- R6: Only the immediately preceding symbol counts, and 00 and 11 are equivalent as a predecessor. For example, the sequence 10, 00, 11 does not set `z_out`.
- R7: `z_out` is a registered Moore output. It changes only at the rising edge that samples the second symbol of a pair, and does not follow the inputs between edges.
- R8: Reset takes priority over the inputs in the cycle where it is asserted. The stored state is discarded in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | High bit of the input symbol |
| in_b | input | 1 | Low bit of the input symbol |
| z_out | output | 1 | Registered controller output |

## Verification
Each symbol takes effect at the first rising edge after it is driven. The resulting `z_out` is due in that same clock cycle and is read at the following falling edge. The bench also reads `z_out` shortly after each new symbol is driven and before the edge, to confirm that the output still holds its old value. A reference model in the bench advances only once per edge, so every comparison is made against the value for exactly that cycle. Reset, whether applied alone or together with symbols that would otherwise change the output, is checked the same way one edge later.

// File: rtl/pairseq_pkg.sv
package pairseq_pkg;

   // Class of an input symbol as remembered for the next pair decision
   typedef enum logic [1:0] {
      CLS_FLAT = 2'd0,   // 00 or 11
      CLS_RISE = 2'd1,   // 01
      CLS_FALL = 2'd2    // 10
   } sym_class_e;

   // Effect of one ordered pair on the output bit
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_CLR  = 2'd1,
      ACT_SET  = 2'd2,
      ACT_TGL  = 2'd3
   } pair_act_e;

   // State storage variants
   localparam int unsigned ENC_BINARY = 0;
   localparam int unsigned ENC_ONEHOT = 1;

   localparam int unsigned NUM_CLASSES = 3;
   localparam int unsigned NUM_STATES  = NUM_CLASSES * 2;

endpackage

// File: rtl/pairseq_classify.sv
module pairseq_classify
   import pairseq_pkg::*;
(
   input  logic       sym_hi,
   input  logic       sym_lo,
   output sym_class_e cls,
   output logic       is_both_high
);

   always_comb begin
      unique case ({sym_hi, sym_lo})
         2'b01:   cls = CLS_RISE;
         2'b10:   cls = CLS_FALL;
         default: cls = CLS_FLAT;
      endcase
   end

   assign is_both_high = sym_hi & sym_lo;

endmodule

// File: rtl/pairseq_rule.sv
module pairseq_rule
   import pairseq_pkg::*;
(
   input  sym_class_e prev_cls,
   input  sym_class_e cur_cls,
   input  logic       cur_both_high,
   output pair_act_e  act
);

   always_comb begin
      act = ACT_HOLD;
      unique case (prev_cls)
         CLS_RISE: if (cur_both_high)         act = ACT_CLR;
         CLS_FALL: if (cur_both_high)         act = ACT_SET;
                   else if (cur_cls == CLS_RISE) act = ACT_TGL;
         default:  act = ACT_HOLD;
      endcase
   end

endmodule

// File: rtl/pairseq_state.sv
module pairseq_state
   import pairseq_pkg::*;
#(
   parameter int unsigned STATE_ENC = ENC_BINARY
) (
   input  logic       clk,
   input  logic       rst,
   input  sym_class_e nxt_cls,
   input  pair_act_e  act,
   output sym_class_e prev_cls,
   output logic       z_q
);

   initial begin
      if (STATE_ENC != ENC_BINARY && STATE_ENC != ENC_ONEHOT)
         $error("pairseq_state: STATE_ENC must be 0 or 1");
   end

   logic z_nxt;

   always_comb begin
      unique case (act)
         ACT_CLR: z_nxt = 1'b0;
         ACT_SET: z_nxt = 1'b1;
         ACT_TGL: z_nxt = ~z_q;
         default: z_nxt = z_q;
      endcase
   end

   generate
      if (STATE_ENC == ENC_ONEHOT) begin : g_onehot
         // bit index = class*2 + output value
         logic [NUM_STATES-1:0] st_q;
         logic [NUM_STATES-1:0] st_d;

         always_comb begin
            st_d = '0;
            st_d[{nxt_cls, z_nxt}] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) st_q <= {{(NUM_STATES-1){1'b0}}, 1'b1};
            else     st_q <= st_d;
         end

         always_comb begin
            prev_cls = CLS_FLAT;
            z_q      = 1'b0;
            for (int i = 0; i < NUM_STATES; i++) begin
               if (st_q[i]) begin
                  prev_cls = sym_class_e'(i / 2);
                  z_q      = i[0];
               end
            end
         end

         p_onehot_legal_r1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> ($countones(st_q) == 1))
            else $error("one-hot state not legal");
      end else begin : g_binary
         sym_class_e cls_q;
         logic       zb_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               cls_q <= CLS_FLAT;
               zb_q  <= 1'b0;
            end else begin
               cls_q <= nxt_cls;
               zb_q  <= z_nxt;
            end
         end

         assign prev_cls = cls_q;
         assign z_q      = zb_q;
      end
   endgenerate

endmodule

// File: rtl/pairseq_ctrl.sv
module pairseq_ctrl
   import pairseq_pkg::*;
#(
   parameter int unsigned STATE_ENC = ENC_BINARY
) (
   input  logic clk,
   input  logic rst,
   input  logic in_a,
   input  logic in_b,
   output logic z_out
);

   sym_class_e cur_cls;
   sym_class_e prev_cls;
   logic       cur_hh;
   pair_act_e  act;
   logic       z_q;

   pairseq_classify u_classify (
      .sym_hi       (in_a),
      .sym_lo       (in_b),
      .cls          (cur_cls),
      .is_both_high (cur_hh)
   );

   pairseq_rule u_rule (
      .prev_cls      (prev_cls),
      .cur_cls       (cur_cls),
      .cur_both_high (cur_hh),
      .act           (act)
   );

   pairseq_state #(.STATE_ENC(STATE_ENC)) u_state (
      .clk      (clk),
      .rst      (rst),
      .nxt_cls  (cur_cls),
      .act      (act),
      .prev_cls (prev_cls),
      .z_q      (z_q)
   );

   assign z_out = z_q;

   // Reset and pair rules, checked against the port inputs
   p_reset_zero_r1: assert property (@(posedge clk)
      rst |=> (!z_out && prev_cls == CLS_FLAT))
      else $error("reset state wrong");

   p_clear_r2: assert property (@(posedge clk) disable iff (rst)
      (prev_cls == CLS_RISE && in_a && in_b) |=> !z_out)
      else $error("rise then 11 did not clear");

   p_set_r3: assert property (@(posedge clk) disable iff (rst)
      (prev_cls == CLS_FALL && in_a && in_b) |=> z_out)
      else $error("fall then 11 did not set");

   p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
      (prev_cls == CLS_FALL && !in_a && in_b) |=> (z_out != $past(z_out)))
      else $error("fall then rise did not invert");

   p_hold_flat_r5: assert property (@(posedge clk) disable iff (rst)
      (prev_cls == CLS_FLAT || (!in_a && !in_b)) |=> $stable(z_out))
      else $error("output moved on a neutral pair");

   p_history_r6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (prev_cls == ($past(in_a) ^ $past(in_b) ?
                             ($past(in_a) ? CLS_FALL : CLS_RISE) : CLS_FLAT)))
      else $error("remembered class wrong");

endmodule

// File: tb/pairseq_ctrl_bench.sv
`timescale 1ns/1ps
module pairseq_ctrl_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_a = 1'b0;
   logic in_b = 1'b0;
   logic z_out;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // model state: prev class 0 flat, 1 rise, 2 fall
   int m_prev = 0;
   bit m_z = 0;

   always #5 clk = ~clk;

   pairseq_ctrl u_pairseq_ctrl (
      .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .z_out(z_out)
   );

   function automatic int cls_of(bit a, bit b);
      if (!a && b) return 1;
      if (a && !b) return 2;
      return 0;
   endfunction

   function automatic bit next_z(int prev, bit a, bit b, bit z);
      if (prev == 1 && a && b)  return 1'b0;   // R2
      if (prev == 2 && a && b)  return 1'b1;   // R3
      if (prev == 2 && !a && b) return ~z;     // R4
      return z;                                // R5
   endfunction

   function automatic string tag_of(int prev, bit a, bit b);
      if (prev == 1 && a && b)  return "R2";
      if (prev == 2 && a && b)  return "R3";
      if (prev == 2 && !a && b) return "R4";
      return "R5";
   endfunction

   task automatic check(bit act_v, bit exp_v, string tag);
      checks++;
      if (act_v !== exp_v) begin
         failures++;
         $display("FAIL %s: z_out actual=%0b expected=%0b", tag, act_v, exp_v);
      end
   endtask

   // Drive a symbol at the falling edge, confirm no early change (R7),
   // then check the result at the next falling edge.
   task automatic step(bit a, bit b, string tag_override = "");
      string tag;
      in_a = a;
      in_b = b;
      #1;
      check(z_out, m_z, "R7");
      tag = (tag_override != "") ? tag_override : tag_of(m_prev, a, b);
      m_z = next_z(m_prev, a, b, m_z);
      m_prev = cls_of(a, b);
      @(posedge clk);
      @(negedge clk);
      check(z_out, m_z, tag);
   endtask

   task automatic do_reset(bit a, bit b);
      in_a = a;
      in_b = b;
      rst = 1'b1;
      m_prev = 0;
      m_z = 0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check(z_out, 1'b0, "R1");

      // R1: first 11 after reset sees a flat predecessor
      step(1, 1, "R1");
      // R3 set, then R2 clear
      step(1, 0); step(1, 1, "R3");
      step(0, 1); step(1, 1, "R2");
      // R4 toggle twice in a row: 10,01,10,01
      step(1, 0); step(0, 1, "R4");
      step(1, 0); step(0, 1, "R4");
      // R6: intervening 00 breaks the pair
      step(1, 0); step(0, 0, "R6"); step(1, 1, "R6");
      // R6: 11 and 00 equivalent as predecessor
      step(1, 1); step(0, 1, "R6");
      step(0, 0); step(0, 1, "R6");
      // R5: second symbol 00 after fall/rise
      step(1, 0); step(1, 1, "R3"); step(0, 1); step(0, 0, "R5");

      // R8: reset while a set pair is presented
      step(1, 0);
      do_reset(1, 1);
      check(z_out, 1'b0, "R8");
      step(0, 1, "R8");

      // random section
      for (int i = 0; i < 3000; i++) begin
         bit ra, rb;
         ra = 1'($urandom);
         rb = 1'($urandom);
         if (($urandom % 400) == 0) begin
            do_reset(ra, rb);
            check(z_out, 1'b0, "R8");
         end else begin
            step(ra, rb);
         end
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule